// File: doc/BRIEF.md
# UTOPIA Level 2 Receive Polling Master

This block is the ingress-side bus master for a UTOPIA Level 2 link. It shares one data bus with up to 31 PHY devices. It steps a 5-bit address across the PHYs it owns, one per clock. Each PHY answers on a shared cell-available line one clock after its address appears. The master picks the first answering PHY whose internal queue has room. It puts that PHY's address on the bus for one clock with the enable still high, then pulls the active-low enable down and receives the cell.

Incoming words are framed by the start-of-cell input and counted up to the cell length set by the data width and the cell size. Each framed word is written into the queue of the selected PHY through a one-hot write enable. The word's odd parity is checked on the way. When a cell completes, an increment strobe for that queue lets the queue's packet counter advance. A start-of-cell that arrives inside a cell is passed on with the word, so the queue can drop the partial cell, and counting restarts from it.

Top module: `ul2rx_poll_master`

## Requirements
- R1: While reset is asserted (asynchronously, active low), the enable output is high and the write enable, increment and parity-error outputs are all zero.
- R2: While no transfer is in progress, the address output steps through 0 to N_PHY-1, one value per clock, wrapping to 0, with the enable high.
- R3: The cell-available input sampled one clock after address A was driven belongs to PHY A. If it is high and A's almost-full bit is clear, address A is driven for one clock with the enable high, and the enable goes low on the next clock.
- R4: A PHY whose almost-full bit is set in the clock its cell-available is sampled is never selected, whatever its cell-available says.
- R5: While the enable is low, the address output holds the null address 31.
- R6: A word on the bus at a clock edge with the enable low is accepted if the start-of-cell input is 1 or a cell is already open. One clock later, wr_en shows the one-hot bit of the selected queue (bit i = PHY i), wr_data shows the word and wr_soc shows its start-of-cell flag.
- R7: Words that arrive with the enable low but before any start-of-cell are not written and raise no parity error.
- R8: Parity is odd. For an accepted word whose data bits plus the parity input hold an even number of ones, par_err is high for exactly the clock in which that word is written, and the word is still written.
- R9: A cell is complete after CELL_BYTES*8/DW accepted words counted from its start-of-cell. cell_inc shows the queue's one-hot bit in the same clock as the last word's write enable, and the enable output is already high in that clock.
- R10: A start-of-cell inside an open cell is written with wr_soc = 1 and restarts the word count, so the cell ends a full cell length after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| q_afull | input | N_PHY | Per-queue almost-full flags, bit i for PHY i |
| rx_data | input | DW | Bus data from the selected PHY |
| rx_par | input | 1 | Odd parity bit for rx_data |
| rx_soc | input | 1 | Start-of-cell flag for the current word |
| rx_clav | input | 1 | Cell-available answer from the last polled PHY |
| rx_addr | output | 5 | Poll/select address, 31 = null |
| rx_enb_n | output | 1 | Active-low receive enable |
| wr_data | output | DW | Word written to the queue |
| wr_soc | output | 1 | Start-of-cell flag travelling with wr_data |
| wr_en | output | N_PHY | One-hot queue write enable |
| cell_inc | output | N_PHY | One-hot completed-cell strobe |
| par_err | output | 1 | Parity error pulse aligned with the bad word |

## Verification
Every clock, the assertions check that the null address is held while the enable is low. They check that writes are one-hot and only follow an enabled clock, and that each parity error coincides with a write. They also check that a completed-cell strobe matches the last write and comes with the enable already released. Each fall of the enable is traced back to a cell-available answer from a queue that was not almost full. The order of the poll sweep, the framing of words before a start-of-cell, the word count of a cell, the restart on a mid-cell start-of-cell and the data carried through can only be shown by the bench's scenarios.

// File: rtl/ul2rx_pkg.sv
package ul2rx_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] NULL_ADDR = 5'd31;

  typedef enum logic [1:0] {
    ST_POLL = 2'd0,
    ST_SEL  = 2'd1,
    ST_XFER = 2'd2
  } rx_state_e;
endpackage

// File: rtl/ul2rx_poll_ring.sv
// Round-robin poll pointer: advances one PHY per enabled clock.
module ul2rx_poll_ring #(
  parameter int unsigned N_PHY = 4,
  parameter int unsigned IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [IW-1:0] LAST = IW'(N_PHY - 1);

  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (ptr_q == LAST) ptr_d = '0;
      else               ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/ul2rx_odd_par.sv
// Odd-parity checker, folded per byte lane.
module ul2rx_odd_par #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          par,
  output logic          bad
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned NLANE = DW / 8;

  logic [NLANE-1:0] lane;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane[g] = ^data[g*8 +: 8];
  end

  assign bad = ~(^{lane, par});
endmodule

// File: rtl/ul2rx_cell_track.sv
// Word framing: opens a cell on start-of-cell, counts words, flags the last.
module ul2rx_cell_track #(
  parameter int unsigned WPC = 52,
  parameter int unsigned CW  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic soc,
  output logic accept,
  output logic last
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [CW-1:0] END_IDX = CW'(WPC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    accept = 1'b0;
    last   = 1'b0;
    cnt_d  = cnt_q;
    if (take) begin
      if (soc) begin
        accept = 1'b1;
        last   = (WPC == 1);
        cnt_d  = last ? '0 : CW'(1);
      end else if (cnt_q != '0) begin
        accept = 1'b1;
        last   = (cnt_q == END_IDX);
        cnt_d  = last ? '0 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ul2rx_wr_stage.sv
// Output register stage toward the per-PHY queues.
module ul2rx_wr_stage #(
  parameter int unsigned N_PHY = 4,
  parameter int unsigned IW    = 2,
  parameter int unsigned DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             last,
  input  logic             bad,
  input  logic             soc,
  input  logic [DW-1:0]    data,
  input  logic [IW-1:0]    q,
  output logic [DW-1:0]    wr_data,
  output logic             wr_soc,
  output logic [N_PHY-1:0] wr_en,
  output logic [N_PHY-1:0] cell_inc,
  output logic             par_err
);
  timeunit 1ns;
  timeprecision 1ps;

  logic          vld_q;
  logic          last_q, bad_q, soc_q;
  logic [DW-1:0] data_q;
  logic [IW-1:0] q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= acc;
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      data_q <= data;
      soc_q  <= soc;
      last_q <= last;
      bad_q  <= bad;
      q_q    <= q;
    end
  end

  for (genvar p = 0; p < N_PHY; p++) begin : g_q
    assign wr_en[p]    = vld_q && (q_q == IW'(p));
    assign cell_inc[p] = vld_q && last_q && (q_q == IW'(p));
  end

  assign wr_data = data_q;
  assign wr_soc  = soc_q;
  assign par_err = vld_q && bad_q;
endmodule

// File: rtl/ul2rx_poll_master.sv
module ul2rx_poll_master
  import ul2rx_pkg::*;
#(
  parameter int unsigned N_PHY      = 4,
  parameter int unsigned DW         = 8,
  parameter int unsigned CELL_BYTES = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PHY-1:0]  q_afull,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_par,
  input  logic              rx_soc,
  input  logic              rx_clav,
  output logic [ADDR_W-1:0] rx_addr,
  output logic              rx_enb_n,
  output logic [DW-1:0]     wr_data,
  output logic              wr_soc,
  output logic [N_PHY-1:0]  wr_en,
  output logic [N_PHY-1:0]  cell_inc,
  output logic              par_err
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned IW  = (N_PHY > 1) ? $clog2(N_PHY) : 1;
  localparam int unsigned WPC = CELL_BYTES / (DW / 8);
  localparam int unsigned CW  = $clog2(WPC + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  rx_state_e     st_q, st_d;
  logic [IW-1:0] sel_q, sel_d;
  logic [IW-1:0] pa_q, pa_d;
  logic          pv_q, pv_d;
  logic [IW-1:0] ptr;
  logic          adv, take, acc, last, bad, eligible;

  assign adv  = (st_q == ST_POLL);
  assign take = (st_q == ST_XFER);

  ul2rx_poll_ring #(.N_PHY(N_PHY), .IW(IW)) u_ring (
    .clk(clk), .rst_n(rst_n_i), .adv(adv), .ptr(ptr)
  );

  ul2rx_cell_track #(.WPC(WPC), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n_i), .take(take), .soc(rx_soc),
    .accept(acc), .last(last)
  );

  ul2rx_odd_par #(.DW(DW)) u_par (
    .data(rx_data), .par(rx_par), .bad(bad)
  );

  ul2rx_wr_stage #(.N_PHY(N_PHY), .IW(IW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n_i), .acc(acc), .last(last), .bad(bad),
    .soc(rx_soc), .data(rx_data), .q(sel_q),
    .wr_data(wr_data), .wr_soc(wr_soc), .wr_en(wr_en),
    .cell_inc(cell_inc), .par_err(par_err)
  );

  // The answer on rx_clav belongs to the address driven one clock earlier.
  assign eligible = pv_q && rx_clav && !q_afull[pa_q];

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    pa_d  = pa_q;
    pv_d  = pv_q;
    unique case (st_q)
      ST_POLL: begin
        pa_d = ptr;
        pv_d = 1'b1;
        if (eligible) begin
          st_d  = ST_SEL;
          sel_d = pa_q;
          pv_d  = 1'b0;
        end
      end
      ST_SEL:  st_d = ST_XFER;
      ST_XFER: if (acc && last) st_d = ST_POLL;
      default: st_d = ST_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q <= ST_POLL;
      pv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      pv_q <= pv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sel_q <= '0;
      pa_q  <= '0;
    end else begin
      sel_q <= sel_d;
      pa_q  <= pa_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_POLL: rx_addr = ADDR_W'(ptr);
      ST_SEL:  rx_addr = ADDR_W'(sel_q);
      default: rx_addr = NULL_ADDR;
    endcase
  end

  assign rx_enb_n = (st_q != ST_XFER);
endmodule

// File: rtl/ul2rx_checker.sv
module ul2rx_checker
  import ul2rx_pkg::*;
#(
  parameter int unsigned N_PHY = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rx_addr,
  input logic              rx_enb_n,
  input logic              rx_clav,
  input logic [N_PHY-1:0]  q_afull,
  input logic [N_PHY-1:0]  wr_en,
  input logic [N_PHY-1:0]  cell_inc,
  input logic              par_err
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [ADDR_W-1:0] addr_d1;
  logic [N_PHY-1:0]  afull_d1, afull_d2;
  logic              clav_d1, clav_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_d1  <= NULL_ADDR;
      afull_d1 <= '1;
      afull_d2 <= '1;
      clav_d1  <= 1'b0;
      clav_d2  <= 1'b0;
    end else begin
      addr_d1  <= rx_addr;
      afull_d1 <= q_afull;
      afull_d2 <= afull_d1;
      clav_d1  <= rx_clav;
      clav_d2  <= clav_d1;
    end
  end

  a_r5_null_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enb_n |-> rx_addr == NULL_ADDR);

  a_r4_select_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_enb_n) |-> (addr_d1 < ADDR_W'(N_PHY)) && clav_d2 &&
                        !afull_d2[addr_d1[$clog2(N_PHY > 1 ? N_PHY : 2)-1:0]]);

  a_r6_write_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  a_r6_write_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> $past(!rx_enb_n));

  a_r8_perr_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> (|wr_en));

  a_r9_inc_on_last_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|cell_inc) |-> (cell_inc == wr_en) && rx_enb_n);
endmodule

bind ul2rx_poll_master ul2rx_checker #(.N_PHY(N_PHY)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_addr(rx_addr), .rx_enb_n(rx_enb_n),
  .rx_clav(rx_clav), .q_afull(q_afull), .wr_en(wr_en),
  .cell_inc(cell_inc), .par_err(par_err)
);

// File: tb/tb_ul2rx_poll_master.sv
module tb_ul2rx_poll_master;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NPHY = 4;
  localparam int DW   = 8;
  localparam int CB   = 52;
  localparam int WPC  = CB / (DW / 8);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NPHY-1:0] q_afull;
  logic [DW-1:0]   rx_data;
  logic            rx_par, rx_soc, rx_clav;
  logic [4:0]      rx_addr;
  logic            rx_enb_n;
  logic [DW-1:0]   wr_data;
  logic            wr_soc;
  logic [NPHY-1:0] wr_en, cell_inc;
  logic            par_err;

  always #2.5 clk = ~clk;

  ul2rx_poll_master #(.N_PHY(NPHY), .DW(DW), .CELL_BYTES(CB)) dut (
    .clk(clk), .rst_n(rst_n), .q_afull(q_afull), .rx_data(rx_data),
    .rx_par(rx_par), .rx_soc(rx_soc), .rx_clav(rx_clav),
    .rx_addr(rx_addr), .rx_enb_n(rx_enb_n), .wr_data(wr_data),
    .wr_soc(wr_soc), .wr_en(wr_en), .cell_inc(cell_inc), .par_err(par_err)
  );

  // PHY model: answers for the address seen at the previous edge.
  logic [4:0]      addr_q;
  logic [NPHY-1:0] clav_mask;
  always @(posedge clk) addr_q <= rx_addr;
  assign rx_clav = (addr_q < 5'(NPHY)) && clav_mask[addr_q[1:0]];

  int n_run  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {clav[31:28], afull[27:24], queue[23:22], pre[21:20], perr[15:8], resoc[7:0]}; FF = none
  localparam logic [31:0] VEC [6] = '{
    {4'b0001, 4'b0000, 2'd0, 2'd0, 4'h0, 8'hFF, 8'hFF},
    {4'b0110, 4'b0010, 2'd2, 2'd0, 4'h0, 8'd5,  8'hFF},
    {4'b1000, 4'b0000, 2'd3, 2'd2, 4'h0, 8'hFF, 8'hFF},
    {4'b1111, 4'b1011, 2'd2, 2'd0, 4'h0, 8'hFF, 8'd10},
    {4'b0010, 4'b0000, 2'd1, 2'd0, 4'h0, 8'd0,  8'hFF},
    {4'b0001, 4'b0000, 2'd0, 2'd1, 4'h0, 8'd51, 8'hFF}
  };

  task automatic wait_sel(input int q);
    logic [4:0] prev;
    int n;
    prev = rx_addr;
    n = 0;
    while (rx_enb_n && n < 200) begin
      prev = rx_addr;
      @(negedge clk);
      n++;
    end
    chk(!rx_enb_n && prev == 5'(q), "R3", prev, q);
    chk(rx_addr == 5'd31, "R5", rx_addr, 31);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; q_afull = '0; clav_mask = '0;
    rx_data = '0; rx_par = 1'b1; rx_soc = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rx_enb_n == 1'b1, "R1", rx_enb_n, 1);
    chk(wr_en == '0 && cell_inc == '0 && par_err == 1'b0, "R1", {wr_en, cell_inc, par_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 poll sweep
    begin
      logic [4:0] pa;
      pa = rx_addr;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk(rx_enb_n && rx_addr == 5'((pa + 1) % NPHY), "R2", rx_addr, (pa + 1) % NPHY);
        pa = rx_addr;
      end
    end

    // Vector table walk
    for (int r = 0; r < 6; r++) begin
      logic [31:0] v;
      int q, pre, perr, resoc, e, w;
      bit done, restarted, soc_b, last;
      logic [DW-1:0] d;
      v = VEC[r];
      q = int'(v[23:22]); pre = int'(v[21:20]);
      perr = int'(v[15:8]); resoc = int'(v[7:0]);
      q_afull = v[27:24];
      clav_mask = v[31:28];
      wait_sel(q);
      clav_mask = '0;
      for (int j = 0; j < pre; j++) begin
        rx_data = DW'(8'hE0 + j);
        rx_par  = ^rx_data;          // wrong parity, must be ignored
        rx_soc  = 1'b0;
        @(negedge clk);
        chk(wr_en == '0 && par_err == 1'b0, "R7", {wr_en, par_err}, 0);
      end
      e = 0; w = 0; done = 0; restarted = 0;
      while (!done) begin
        soc_b = (e == 0);
        if (w == resoc && !restarted) begin
          soc_b = 1'b1; e = 0; restarted = 1'b1;
        end
        d = DW'(w * 5 + q * 64 + 3);
        rx_data = d;
        rx_soc  = soc_b;
        rx_par  = (w == perr) ? ^d : ~^d;
        @(negedge clk);
        last = (e == WPC - 1);
        chk(wr_en == NPHY'(1 << q) && wr_data == d, "R6", {wr_en, wr_data}, {NPHY'(1 << q), d});
        chk(wr_soc == soc_b, (resoc != 255 && w == resoc) ? "R10" : "R6", wr_soc, soc_b);
        chk(par_err == (w == perr), "R8", par_err, (w == perr));
        if (last) begin
          chk(cell_inc == NPHY'(1 << q) && rx_enb_n, (resoc != 255) ? "R10" : "R9",
              {cell_inc, rx_enb_n}, {NPHY'(1 << q), 1'b1});
        end else if (cell_inc != '0 || rx_enb_n) begin
          chk(1'b0, "R9", {cell_inc, rx_enb_n}, 0);
        end
        e++; w++; done = last;
      end
      rx_soc = 1'b0;
      q_afull = '0;
    end

    // R4: every PHY answers but every queue is almost full
    begin
      int lows;
      lows = 0;
      q_afull = '1;
      clav_mask = '1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!rx_enb_n) lows++;
      end
      chk(lows == 0, "R4", lows, 0);
      clav_mask = '0;
      q_afull = '0;
    end

    // R1: reset in the middle of a transfer
    clav_mask = 4'b0100;
    wait_sel(2);
    clav_mask = '0;
    for (int j = 0; j < 3; j++) begin
      rx_data = DW'(j + 1); rx_soc = (j == 0); rx_par = ~^rx_data;
      @(negedge clk);
    end
    rst_n = 1'b0;
    #1;
    chk(rx_enb_n == 1'b1 && wr_en == '0 && cell_inc == '0, "R1", {rx_enb_n, wr_en}, 1 << NPHY);
    rx_soc = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_enb_n == 1'b1 && rx_addr < 5'(NPHY), "R2", rx_addr, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule